// File: doc/BRIEF.md
# Synchronous Line Output Stage with Forced Mark Idle

This block is the last stage of a synchronous bit-oriented transmitter. The framing logic hands it one unencoded bit per bit time, marked by a one-clock strobe. The block either encodes that bit onto the transmit data pin, as plain NRZ or as NRZI, or holds the line in mark idle. Three end-of-activity markers come with the bit stream: the last bit of a closing flag, the last bit of an abort, and a command to go idle. When mark idle is selected, any of these markers moves the line into the idle state.

In bit-oriented framing mode with NRZI and mark idle all selected, the line is driven high on the bit time that follows the final marked bit. The NRZI reference is reset to high at the same point, so the idle line never depends on the data that came before it. In other synchronous modes, an NRZI line holds whatever level it had. When automatic opening flags are enabled, a pending frame request pulls the line out of idle and asks the framer to begin with a flag. Without that option, software leaves idle by clearing the mark-idle selection, after which the framer's flags are sent.

Top module: `tx_line_stage`

## Requirements
- R1: During and after reset, and until the first strobe, `txd` is 1, `line_idle` is 1 and `open_go` is 0.
- R2: While running with NRZI selected, each strobe updates `txd` at that clock edge. A 0 bit inverts the level and a 1 bit keeps it.
- R3: While running with NRZI not selected, each strobe copies `tx_bit` to `txd`.
- R4: In framing mode (`cfg_sdlc`=1) with NRZI and mark idle selected, the strobe after the line enters idle drives `txd` to 1, whatever the prior level. The NRZI reference is then high.
- R5: Any one of the markers brings the line to idle (`line_idle`=1) when it is set on a strobe with mark idle selected. The marker bits are: `end_mark[0]` for the last closing-flag bit, `end_mark[1]` for the last abort bit, and `end_mark[2]` for the idle command. The marked bit itself is still encoded onto `txd`.
- R6: While idle in framing mode with mark idle selected, `txd` stays 1 on every strobe, whatever `tx_bit` is.
- R7: Outside framing mode (`cfg_sdlc`=0) with NRZI and mark idle selected, `txd` keeps its previous level while idle, and no forcing takes place.
- R8: With mark idle not selected, the markers have no effect: `line_idle` stays 0 and encoding continues.
- R9: When the line is idle in framing mode with `cfg_auto_open`=1 and `frame_req`=1 on a strobe, `open_go` pulses for exactly one clock. On that same edge `line_idle` falls, and the next bit is encoded from a high reference.
- R10: With `cfg_auto_open`=0, `frame_req` is ignored while idle. Clearing `cfg_mark_idle` makes the next strobe leave idle.
- R11: Without a strobe, `txd` and `line_idle` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-clock bit-time strobe |
| tx_bit | input | 1 | Unencoded serial bit from the framer |
| end_mark | input | END_SRCS | End-of-activity markers (closing flag, abort, idle command) |
| cfg_sdlc | input | 1 | Bit-oriented framing mode selected |
| cfg_nrzi | input | 1 | NRZI encoding selected |
| cfg_mark_idle | input | 1 | Mark idle selected (otherwise flag idle) |
| cfg_auto_open | input | 1 | Automatic opening flag enabled |
| frame_req | input | 1 | Framer has a frame waiting |
| txd | output | 1 | Transmit data pin |
| line_idle | output | 1 | Line is in mark idle |
| open_go | output | 1 | One-clock pulse: framer may begin with an opening flag |

## Verification
The hardest case to reach from the ports is the one the forcing exists for: entering idle while the NRZI line is low. The stimulus tracks the expected line level. Before sending each marked bit, it inserts a 0 bit whenever that is needed to bring the level low, and then sends the marked bit as a 1 so the line stays low. The next strobe must then show the forced rise. The same low-level entry is repeated outside framing mode to show that the level is held there. The mode is then switched to framing while the line sits idle, to show the force acting on an idle line.

// File: rtl/txl_pkg.sv
package txl_pkg;
   typedef enum logic {
      LN_RUN  = 1'b0,
      LN_MARK = 1'b1
   } ln_state_t;
endpackage

// File: rtl/txl_idle_ctl.sv
module txl_idle_ctl
   import txl_pkg::*;
#(
   parameter int END_SRCS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                stb,
   input  logic [END_SRCS-1:0] end_mark,
   input  logic                mark_sel,
   input  logic                sdlc,
   input  logic                nrzi,
   input  logic                auto_open,
   input  logic                frame_req,
   output ln_state_t           state,
   output logic                force_hi,
   output logic                open_go
);
   logic any_end;
   logic auto_start;

   assign any_end    = |end_mark;
   assign auto_start = auto_open && sdlc && frame_req;

   // Forcing is only meaningful on an NRZI framed line in mark idle
   assign force_hi = (state == LN_MARK) && sdlc && nrzi && mark_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= LN_MARK;
         open_go <= 1'b0;
      end else begin
         open_go <= 1'b0;
         if (stb) begin
            unique case (state)
               LN_RUN: begin
                  if (mark_sel && any_end) state <= LN_MARK;
               end
               LN_MARK: begin
                  if (!mark_sel) begin
                     state <= LN_RUN;
                  end else if (auto_start) begin
                     state   <= LN_RUN;
                     open_go <= 1'b1;
                  end
               end
               default: state <= LN_MARK;
            endcase
         end
      end
   end
endmodule

// File: rtl/txl_coder.sv
module txl_coder #(
   parameter bit HAS_NRZI = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic bit_in,
   input  logic nrzi_en,
   input  logic hold_mark,
   input  logic force_hi,
   output logic line
);
   logic lvl_q;
   logic lvl_d;

   generate
      if (HAS_NRZI) begin : g_nrzi
         always_comb begin
            if (hold_mark)
               lvl_d = (nrzi_en && !force_hi) ? lvl_q : 1'b1;
            else if (nrzi_en)
               lvl_d = bit_in ? lvl_q : ~lvl_q;
            else
               lvl_d = bit_in;
         end
      end else begin : g_nrz
         logic unused_cfg;
         assign unused_cfg = nrzi_en ^ force_hi;
         always_comb lvl_d = hold_mark ? 1'b1 : bit_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lvl_q <= 1'b1;
      else if (stb) lvl_q <= lvl_d;
   end

   assign line = lvl_q;
endmodule

// File: rtl/tx_line_stage.sv
module tx_line_stage
   import txl_pkg::*;
#(
   parameter int END_SRCS = 3,
   parameter bit HAS_NRZI = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_stb,
   input  logic                tx_bit,
   input  logic [END_SRCS-1:0] end_mark,
   input  logic                cfg_sdlc,
   input  logic                cfg_nrzi,
   input  logic                cfg_mark_idle,
   input  logic                cfg_auto_open,
   input  logic                frame_req,
   output logic                txd,
   output logic                line_idle,
   output logic                open_go
);
   generate
      if (END_SRCS < 1) begin : g_bad_cfg
         $error("tx_line_stage: END_SRCS must be at least 1");
      end
   endgenerate

   ln_state_t st;
   logic      force_hi;

   txl_idle_ctl #(.END_SRCS(END_SRCS)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb       (bit_stb),
      .end_mark  (end_mark),
      .mark_sel  (cfg_mark_idle),
      .sdlc      (cfg_sdlc),
      .nrzi      (cfg_nrzi),
      .auto_open (cfg_auto_open),
      .frame_req (frame_req),
      .state     (st),
      .force_hi  (force_hi),
      .open_go   (open_go)
   );

   txl_coder #(.HAS_NRZI(HAS_NRZI)) u_coder (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb       (bit_stb),
      .bit_in    (tx_bit),
      .nrzi_en   (cfg_nrzi),
      .hold_mark (st == LN_MARK),
      .force_hi  (force_hi),
      .line      (txd)
   );

   assign line_idle = (st == LN_MARK);
endmodule

// File: rtl/tx_line_stage_chk.sv
module tx_line_stage_chk #(
   parameter bit HAS_NRZI = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic bit_stb,
   input logic tx_bit,
   input logic cfg_sdlc,
   input logic cfg_nrzi,
   input logic cfg_mark_idle,
   input logic txd,
   input logic line_idle,
   input logic open_go
);
   // R4 / R6: idle with mark selected gives a high line, except on unframed NRZI
   a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && line_idle && cfg_mark_idle && !(cfg_nrzi && !cfg_sdlc)) |=> txd);

   // R7: unframed NRZI mark idle keeps its level
   a_r7_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && line_idle && cfg_mark_idle && cfg_nrzi && !cfg_sdlc) |=> $stable(txd));

   // R9: start pulse lasts one clock and coincides with leaving idle
   a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      open_go |=> !open_go);
   a_r9_left_idle: assert property (@(posedge clk) disable iff (!rst_n)
      open_go |-> !line_idle);

   // R11: nothing moves between strobes
   a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb |=> ($stable(txd) && $stable(line_idle)));

   generate
      if (HAS_NRZI) begin : g_nrzi_chk
         // R2: encoding of a running NRZI line
         a_r2_zero_flips: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_stb && !line_idle && cfg_nrzi && !tx_bit) |=> (txd != $past(txd)));
         a_r2_one_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_stb && !line_idle && cfg_nrzi && tx_bit) |=> $stable(txd));
      end
   endgenerate
endmodule

bind tx_line_stage tx_line_stage_chk #(.HAS_NRZI(HAS_NRZI)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bit_stb       (bit_stb),
   .tx_bit        (tx_bit),
   .cfg_sdlc      (cfg_sdlc),
   .cfg_nrzi      (cfg_nrzi),
   .cfg_mark_idle (cfg_mark_idle),
   .txd           (txd),
   .line_idle     (line_idle),
   .open_go       (open_go)
);

// File: tb/tx_line_stage_test.sv
module tx_line_stage_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_stb = 1'b0;
   logic       tx_bit = 1'b1;
   logic [2:0] end_mark = 3'b000;
   logic       cfg_sdlc = 1'b1;
   logic       cfg_nrzi = 1'b1;
   logic       cfg_mark_idle = 1'b0;
   logic       cfg_auto_open = 1'b0;
   logic       frame_req = 1'b0;
   logic       txd, line_idle, open_go;

   int n_chk = 0;
   int n_bad = 0;
   logic exp_lvl = 1'b1;

   always #2.5 clk = ~clk;

   tx_line_stage uut (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .tx_bit(tx_bit),
      .end_mark(end_mark), .cfg_sdlc(cfg_sdlc), .cfg_nrzi(cfg_nrzi),
      .cfg_mark_idle(cfg_mark_idle), .cfg_auto_open(cfg_auto_open),
      .frame_req(frame_req), .txd(txd), .line_idle(line_idle), .open_go(open_go)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   // one bit time: strobe for one clock, sample at the following falling edge
   task automatic strobe(input logic b, input logic [2:0] m);
      @(negedge clk);
      bit_stb = 1'b1; tx_bit = b; end_mark = m;
      @(negedge clk);
      bit_stb = 1'b0; end_mark = 3'b000;
   endtask

   task automatic run_bit(input string req, input logic b);
      strobe(b, 3'b000);
      if (cfg_nrzi) exp_lvl = b ? exp_lvl : ~exp_lvl;
      else          exp_lvl = b;
      chk(req, "txd", txd, exp_lvl);
   endtask

   task automatic t_reset();
      chk("R1", "txd", txd, 1'b1);
      chk("R1", "line_idle", line_idle, 1'b1);
      chk("R1", "open_go", open_go, 1'b0);
   endtask

   task automatic t_nrzi();
      cfg_sdlc = 1; cfg_nrzi = 1; cfg_mark_idle = 0;
      strobe(1'b0, 3'b000);            // leaves idle, level held high
      chk("R10", "leave idle", line_idle, 1'b0);
      chk("R10", "txd", txd, 1'b1);
      exp_lvl = 1'b1;
      foreach (pat_nrzi[i]) run_bit("R2", pat_nrzi[i]);
   endtask
   localparam logic [6:0] pat_nrzi = 7'b0100110;

   task automatic t_nrz();
      cfg_nrzi = 0;
      run_bit("R3", 1'b0);
      run_bit("R3", 1'b1);
      run_bit("R3", 1'b0);
      run_bit("R3", 1'b1);
      cfg_nrzi = 1;
   endtask

   task automatic end_path(input int idx);
      cfg_sdlc = 1; cfg_nrzi = 1; cfg_mark_idle = 0;
      strobe(1'b1, 3'b000);            // ensure running; level unchanged either way
      if (exp_lvl) begin
         strobe(1'b0, 3'b000);
         exp_lvl = 1'b0;
      end
      chk("R4", "low before end", txd, 1'b0);
      cfg_mark_idle = 1;
      strobe(1'b1, 3'(1 << idx));
      chk("R5", $sformatf("marker %0d idle", idx), line_idle, 1'b1);
      chk("R5", "marked bit encoded", txd, 1'b0);
      strobe(1'b0, 3'b000);
      chk("R4", "forced high", txd, 1'b1);
      for (int k = 0; k < 3; k++) begin
         strobe(k[0], 3'b000);
         chk("R6", "mark steady", txd, 1'b1);
         chk("R6", "still idle", line_idle, 1'b1);
      end
      exp_lvl = 1'b1;
   endtask

   task automatic t_ignore();
      cfg_sdlc = 1; cfg_nrzi = 1; cfg_mark_idle = 0;
      strobe(1'b1, 3'b000);
      strobe(1'b0, 3'b111);
      exp_lvl = ~exp_lvl;
      chk("R8", "no idle", line_idle, 1'b0);
      chk("R8", "txd", txd, exp_lvl);
      strobe(1'b1, 3'b001);
      chk("R8", "no idle again", line_idle, 1'b0);
      chk("R8", "txd again", txd, exp_lvl);
   endtask

   task automatic t_non_sdlc();
      cfg_sdlc = 0; cfg_nrzi = 1; cfg_mark_idle = 0;
      strobe(1'b1, 3'b000);
      if (exp_lvl) begin
         strobe(1'b0, 3'b000);
         exp_lvl = 1'b0;
      end
      cfg_mark_idle = 1;
      strobe(1'b1, 3'b001);
      chk("R7", "idle", line_idle, 1'b1);
      for (int k = 0; k < 3; k++) begin
         strobe(1'b0, 3'b000);
         chk("R7", "level held low", txd, 1'b0);
      end
      cfg_sdlc = 1;
      strobe(1'b0, 3'b000);
      chk("R4", "force once framed", txd, 1'b1);
      exp_lvl = 1'b1;
   endtask

   task automatic t_auto();
      cfg_sdlc = 1; cfg_nrzi = 1; cfg_mark_idle = 1; cfg_auto_open = 1;
      chk("R9", "start idle", line_idle, 1'b1);
      frame_req = 1;
      strobe(1'b0, 3'b000);
      frame_req = 0;
      chk("R9", "open_go", open_go, 1'b1);
      chk("R9", "left idle", line_idle, 1'b0);
      chk("R9", "txd still high", txd, 1'b1);
      @(negedge clk);
      chk("R9", "pulse ends", open_go, 1'b0);
      strobe(1'b0, 3'b000);
      chk("R9", "first bit from high", txd, 1'b0);
      exp_lvl = 1'b0;
   endtask

   task automatic t_noauto();
      cfg_auto_open = 0; cfg_mark_idle = 1;
      strobe(1'b1, 3'b100);
      chk("R10", "idle", line_idle, 1'b1);
      frame_req = 1;
      strobe(1'b0, 3'b000);
      strobe(1'b0, 3'b000);
      chk("R10", "request ignored", line_idle, 1'b1);
      chk("R10", "no pulse", open_go, 1'b0);
      chk("R10", "txd high", txd, 1'b1);
      frame_req = 0;
      cfg_mark_idle = 0;
      strobe(1'b0, 3'b000);
      chk("R10", "cleared leaves", line_idle, 1'b0);
      exp_lvl = 1'b1;
      run_bit("R10", 1'b0);
   endtask

   task automatic t_quiet();
      logic t0, i0;
      t0 = txd; i0 = line_idle;
      cfg_mark_idle = 1;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         tx_bit = k[0]; end_mark = 3'b111; frame_req = 1;
      end
      @(negedge clk);
      end_mark = 3'b000; frame_req = 0;
      chk("R11", "txd", txd, t0);
      chk("R11", "line_idle", line_idle, i0);
   endtask

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_nrzi();
      t_nrz();
      for (int p = 0; p < 3; p++) end_path(p);
      t_ignore();
      t_non_sdlc();
      t_auto();
      t_noauto();
      t_quiet();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule